// File: doc/BRIEF.md
# Dual-Mode Host Bus Front End

This block sits between an external host processor bus and the register banks of a two-channel peripheral. A static mode input selects between two bus styles that share one pin set. In strobe mode, separate active-low read and write strobes are qualified by two per-channel chip selects. In select mode, a single chip select frames each transfer, a direction pin marks it as a read or a write, and the second chip-select pin becomes an extra address bit that picks the channel. A 3-bit address picks one of eight registers in the chosen channel.

All bus pins are asynchronous to the system clock. They pass through a synchronizer, and edge detection turns each access into single-cycle read-capture and write-commit events. The byte bus is split into input, output and output-enable signals so that the pad ring can build the bidirectional pin. The two channels' interrupt requests are shaped for the chosen mode. Strobe mode gives each channel its own active-high output, enabled by that channel's control bit. Select mode gives one shared active-low open-drain line. Each channel is modelled here as an eight-register stub. Register 4, bit 3 is the interrupt-output control bit.

Top module: `dual_bus_host_if`

## Requirements
- R1: After reset, every stub register reads 0x00, data_oe_o is 0, and in strobe mode both interrupt enables (irq_a_oe_o, irq_b_oe_o) are 0.
- R2: In strobe mode (mode_intel_i=1), a write to a channel happens when wr_n_i is low and exactly one chip select is low (cs_a_n_i selects channel A, cs_b_n_i selects channel B). The register at addr_i takes the value that data_i holds when the strobe rises, not the value it held while the strobe was low.
- R3: In strobe mode, while rd_n_i is low with exactly one chip select low, data_oe_o is 1 and data_o holds the addressed register of that channel. Both are valid at most 4 clock cycles after the strobe falls, and data_oe_o returns to 0 within 4 cycles after the strobe rises.
- R4: In strobe mode, an access with both chip selects low, or with neither low, neither drives the bus (data_oe_o stays 0) nor changes any register.
- R5: In select mode (mode_intel_i=0), while cs_a_n_i is low and wr_n_i is high, data_oe_o is 1 and data_o holds the addressed register. The channel is chosen by cs_b_n_i: 0 selects A and 1 selects B.
- R6: In select mode, a transfer with cs_a_n_i low and wr_n_i low writes the byte that data_i holds when cs_a_n_i rises. rd_n_i has no effect in this mode.
- R7: In strobe mode, irq_a_oe_o equals bit 3 of channel A register 4, and irq_b_oe_o equals bit 3 of channel B register 4. While enabled, irq_a_o and irq_b_o follow ch_irq_i[0] and ch_irq_i[1] (active high).
- R8: In select mode, irq_a_oe_o is 1 with irq_a_o at 0 whenever some channel requests an interrupt and that channel's register 4 bit 3 is 0. Otherwise irq_a_oe_o is 0, which releases the open-drain line.
- R9: In select mode, irq_b_oe_o is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_intel_i | input | 1 | 1 selects strobe mode, 0 selects select mode; static |
| addr_i | input | 3 | Register address within the channel |
| data_i | input | 8 | Byte from the host bus pins |
| data_o | output | 8 | Read byte toward the bus pins |
| data_oe_o | output | 1 | Drive enable for the bus pins |
| rd_n_i | input | 1 | Read strobe (strobe mode); ignored in select mode |
| wr_n_i | input | 1 | Write strobe (strobe mode) or read-high/write-low direction (select mode) |
| cs_a_n_i | input | 1 | Channel A select (strobe mode) or the single select (select mode) |
| cs_b_n_i | input | 1 | Channel B select (strobe mode) or channel address bit (select mode) |
| ch_irq_i | input | 2 | Interrupt requests from channel A (bit 0) and channel B (bit 1) |
| irq_a_o | output | 1 | Channel A interrupt level, or the shared open-drain level |
| irq_a_oe_o | output | 1 | Drive enable for irq_a_o |
| irq_b_o | output | 1 | Channel B interrupt level |
| irq_b_oe_o | output | 1 | Drive enable for irq_b_o |

## Verification
The assertions assume that mode_intel_i does not change during a transfer. They also assume that address, data and the select-mode channel bit stay stable from the opening edge of an access until several clock cycles after its closing edge, and that every strobe or select level lasts a few clock cycles, so the synchronizer never misses a level. Read and write strobes are assumed never to be low together. The stimulus changes mode only while the bus is idle. It holds every strobe level for at least three cycles and holds address and data for six cycles after each release. The only deliberate data change happens inside an active write, so that the closing-edge commit can be observed.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int DATA_W     = 8;
  localparam int NUM_REGS   = 8;
  localparam int NUM_CH     = 2;
  localparam int CTRL_IDX   = 4;
  localparam int IRQ_EN_BIT = 3;
  localparam int SYNC_W     = 4;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/hbi_decode.sv
module hbi_decode (
  input  logic mode_intel_i,
  input  logic rd_n_i,
  input  logic wr_n_i,
  input  logic cs_a_n_i,
  input  logic cs_b_n_i,
  output logic rd_act_o,
  output logic wr_act_o,
  output logic ch_o
);
  logic one_cs;
  assign one_cs = cs_a_n_i ^ cs_b_n_i;

  always_comb begin
    if (mode_intel_i) begin
      rd_act_o = one_cs & ~rd_n_i & wr_n_i;
      wr_act_o = one_cs & ~wr_n_i & rd_n_i;
      ch_o     = cs_a_n_i;   // A idle means B is the one selected
    end else begin
      // direction pin: high read, low write; second select acts as channel bit
      rd_act_o = ~cs_a_n_i & wr_n_i;
      wr_act_o = ~cs_a_n_i & ~wr_n_i;
      ch_o     = cs_b_n_i;
    end
  end
endmodule

// File: rtl/hbi_reg_stub.sv
module hbi_reg_stub #(
  parameter int  DATA_W     = 8,
  parameter int  NUM_REGS   = 8,
  parameter int  CTRL_IDX   = 4,
  parameter int  IRQ_EN_BIT = 3,
  localparam int ADDR_W     = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_en_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
    end else if (wr_en_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o  = regs_q[raddr_i];
  assign irq_en_o = regs_q[CTRL_IDX][IRQ_EN_BIT];
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq
  import hbi_pkg::*;
(
  input  logic              mode_intel_i,
  input  logic [NUM_CH-1:0] req_i,
  input  logic [NUM_CH-1:0] en_i,
  output logic              irq_a_o,
  output logic              irq_a_oe_o,
  output logic              irq_b_o,
  output logic              irq_b_oe_o
);
  logic shared_req;
  // shared line only honours channels whose control bit is clear
  assign shared_req = |(req_i & ~en_i);

  always_comb begin
    if (mode_intel_i) begin
      irq_a_o    = req_i[0];
      irq_a_oe_o = en_i[0];
      irq_b_o    = req_i[1];
      irq_b_oe_o = en_i[1];
    end else begin
      irq_a_o    = 1'b0;
      irq_a_oe_o = shared_req;
      irq_b_o    = 1'b0;
      irq_b_oe_o = 1'b0;
    end
  end
endmodule

// File: rtl/dual_bus_host_if.sv
module dual_bus_host_if
  import hbi_pkg::*;
#(
  parameter int  DATA_W      = hbi_pkg::DATA_W,
  parameter int  NUM_REGS    = hbi_pkg::NUM_REGS,
  parameter int  SYNC_STAGES = 2,
  localparam int ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_intel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  input  logic              cs_a_n_i,
  input  logic              cs_b_n_i,
  input  logic [NUM_CH-1:0] ch_irq_i,
  output logic              irq_a_o,
  output logic              irq_a_oe_o,
  output logic              irq_b_o,
  output logic              irq_b_oe_o
);
  logic [SYNC_W-1:0] raw_pins, syn_pins;
  assign raw_pins = {cs_b_n_i, cs_a_n_i, wr_n_i, rd_n_i};

  hbi_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL({SYNC_W{1'b1}})) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_pins),
    .q_o   (syn_pins)
  );

  logic rd_act, wr_act, acc_ch;
  hbi_decode u_dec (
    .mode_intel_i(mode_intel_i),
    .rd_n_i      (syn_pins[0]),
    .wr_n_i      (syn_pins[1]),
    .cs_a_n_i    (syn_pins[2]),
    .cs_b_n_i    (syn_pins[3]),
    .rd_act_o    (rd_act),
    .wr_act_o    (wr_act),
    .ch_o        (acc_ch)
  );

  logic              rd_act_q, wr_act_q, wr_ch_q, drive_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_start, wr_start, wr_end;
  logic [NUM_CH-1:0] wr_en, irq_en;
  logic [DATA_W-1:0] bank_rdata [NUM_CH];

  assign rd_start = rd_act & ~rd_act_q;
  assign wr_start = wr_act & ~wr_act_q;
  assign wr_end   = wr_act_q & ~wr_act;   // commit on closing edge

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_act_q  <= 1'b0;
      wr_act_q  <= 1'b0;
      wr_ch_q   <= 1'b0;
      waddr_q   <= '0;
      drive_q   <= 1'b0;
      rd_data_q <= '0;
    end else begin
      rd_act_q <= rd_act;
      wr_act_q <= wr_act;
      if (wr_start) begin
        wr_ch_q <= acc_ch;
        waddr_q <= addr_i;
      end
      if (rd_start) begin
        rd_data_q <= bank_rdata[acc_ch];
        drive_q   <= 1'b1;
      end else if (!rd_act) begin
        drive_q   <= 1'b0;
      end
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_en[c] = wr_end && (wr_ch_q == 1'(c));
    hbi_reg_stub #(
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .CTRL_IDX  (CTRL_IDX),
      .IRQ_EN_BIT(IRQ_EN_BIT)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en[c]),
      .waddr_i (waddr_q),
      .wdata_i (data_i),
      .raddr_i (addr_i),
      .rdata_o (bank_rdata[c]),
      .irq_en_o(irq_en[c])
    );
  end

  assign data_o    = rd_data_q;
  assign data_oe_o = drive_q;

  hbi_irq u_irq (
    .mode_intel_i(mode_intel_i),
    .req_i       (ch_irq_i),
    .en_i        (irq_en),
    .irq_a_o     (irq_a_o),
    .irq_a_oe_o  (irq_a_oe_o),
    .irq_b_o     (irq_b_o),
    .irq_b_oe_o  (irq_b_oe_o)
  );

  // R3: drive only begins after a read capture
  a_r3_oe_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_oe_o) |-> $past(rd_start));
  // R3: drive released one cycle after the read level ends
  a_r3_oe_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rd_act) |=> !data_oe_o);
  // R2: at most one bank written per cycle
  a_r2_single_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_en));
  // R2: write commit is a one-cycle pulse
  a_r2_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |wr_en |=> !(|wr_en));
  // R4: both selects low never opens a read
  a_r4_both_cs_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_intel_i && !syn_pins[2] && !syn_pins[3]) |-> !rd_start);
  // R7: strobe-mode enable follows the channel control bit
  a_r7_enable_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_intel_i && irq_a_oe_o) |-> irq_en[0]);
  // R8: shared line only ever pulls low
  a_r8_open_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_intel_i && irq_a_oe_o) |-> !irq_a_o);
  // R9: second interrupt pin idle in select mode
  a_r9_b_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_intel_i |-> !irq_b_oe_o);
endmodule

// File: tb/tb_dual_bus_host_if.sv
`timescale 1ns/1ps
module tb_dual_bus_host_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_intel = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       doe;
  logic       rd_n = 1'b1, wr_n = 1'b1, csa_n = 1'b1, csb_n = 1'b1;
  logic [1:0] ch_irq = '0;
  logic       ia, iaoe, ib, iboe;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  dual_bus_host_if dut (
    .clk_i(clk), .rst_ni(rst_n), .mode_intel_i(mode_intel),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .rd_n_i(rd_n), .wr_n_i(wr_n), .cs_a_n_i(csa_n), .cs_b_n_i(csb_n),
    .ch_irq_i(ch_irq), .irq_a_o(ia), .irq_a_oe_o(iaoe),
    .irq_b_o(ib), .irq_b_oe_o(iboe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_wr(input logic ch, input logic [2:0] a, input logic [7:0] d);
    addr = a; din = ~d;
    if (ch) csb_n = 1'b0; else csa_n = 1'b0;
    cyc(1); wr_n = 1'b0;
    cyc(3); din = d;
    cyc(2); wr_n = 1'b1;
    cyc(6); csa_n = 1'b1; csb_n = 1'b1;
    cyc(3);
  endtask

  task automatic i_rd(input string tag, input logic ch, input logic [2:0] a, input logic [7:0] e);
    addr = a;
    if (ch) csb_n = 1'b0; else csa_n = 1'b0;
    cyc(1); rd_n = 1'b0;
    cyc(4);
    chk({tag, " oe"}, {7'd0, doe}, 8'd1);
    chk({tag, " data"}, dout, e);
    rd_n = 1'b1;
    cyc(4);
    chk({tag, " release"}, {7'd0, doe}, 8'd0);
    csa_n = 1'b1; csb_n = 1'b1;
    cyc(3);
  endtask

  task automatic m_wr(input logic ch, input logic [2:0] a, input logic [7:0] d);
    addr = a; csb_n = ch; wr_n = 1'b0; din = ~d;
    cyc(1); csa_n = 1'b0;
    cyc(3); din = d;
    cyc(2); csa_n = 1'b1;
    cyc(6); wr_n = 1'b1; csb_n = 1'b1;
    cyc(3);
  endtask

  task automatic m_rd(input string tag, input logic ch, input logic [2:0] a, input logic [7:0] e);
    addr = a; csb_n = ch; wr_n = 1'b1;
    cyc(1); csa_n = 1'b0;
    cyc(4);
    chk({tag, " oe"}, {7'd0, doe}, 8'd1);
    chk({tag, " data"}, dout, e);
    csa_n = 1'b1;
    cyc(4);
    chk({tag, " release"}, {7'd0, doe}, 8'd0);
    csb_n = 1'b1;
    cyc(3);
  endtask

  // {select_mode, write, channel, addr[2:0], data[7:0]}
  localparam int NV = 14;
  localparam logic [13:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 3'd1, 8'hA5},
    {1'b0, 1'b1, 1'b1, 3'd1, 8'h5A},
    {1'b0, 1'b1, 1'b0, 3'd7, 8'h3C},
    {1'b0, 1'b1, 1'b1, 3'd0, 8'hC3},
    {1'b0, 1'b0, 1'b0, 3'd1, 8'hA5},
    {1'b0, 1'b0, 1'b1, 3'd1, 8'h5A},
    {1'b1, 1'b0, 1'b0, 3'd7, 8'h3C},
    {1'b1, 1'b0, 1'b1, 3'd0, 8'hC3},
    {1'b1, 1'b1, 1'b0, 3'd2, 8'h11},
    {1'b1, 1'b1, 1'b1, 3'd2, 8'hEE},
    {1'b0, 1'b0, 1'b0, 3'd2, 8'h11},
    {1'b0, 1'b0, 1'b1, 3'd2, 8'hEE},
    {1'b1, 1'b0, 1'b1, 3'd1, 8'h5A},
    {1'b0, 1'b0, 1'b0, 3'd3, 8'h00}
  };

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R1: reset state
    chk("R1 data_oe", {7'd0, doe}, 8'd0);
    chk("R1 irq_a_oe", {7'd0, iaoe}, 8'd0);
    chk("R1 irq_b_oe", {7'd0, iboe}, 8'd0);
    i_rd("R1 reg B6", 1'b1, 3'd6, 8'h00);

    // table: R2/R6 writes are proven by the R3/R5 reads that follow
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      v = VEC[i];
      mode_intel = ~v[13];
      cyc(2);
      if (v[12]) begin
        if (v[13]) m_wr(v[11], v[10:8], v[7:0]);
        else       i_wr(v[11], v[10:8], v[7:0]);
      end else begin
        if (v[13]) m_rd("R5 table", v[11], v[10:8], v[7:0]);
        else       i_rd("R3 table", v[11], v[10:8], v[7:0]);
      end
    end
    i_rd("R2 data at strobe rise", 1'b0, 3'd7, 8'h3C);

    // R4: both selects low, write then read
    mode_intel = 1'b1; cyc(2);
    addr = 3'd1; din = 8'hFF; csa_n = 1'b0; csb_n = 1'b0; wr_n = 1'b0;
    cyc(5); wr_n = 1'b1; cyc(1); csa_n = 1'b1; csb_n = 1'b1; cyc(4);
    i_rd("R4 both-cs write dropped A", 1'b0, 3'd1, 8'hA5);
    i_rd("R4 both-cs write dropped B", 1'b1, 3'd1, 8'h5A);
    csa_n = 1'b0; csb_n = 1'b0; rd_n = 1'b0;
    cyc(5);
    chk("R4 both-cs read no drive", {7'd0, doe}, 8'd0);
    rd_n = 1'b1; csa_n = 1'b1; csb_n = 1'b1; cyc(3);
    rd_n = 1'b0; cyc(5);
    chk("R4 no-cs read no drive", {7'd0, doe}, 8'd0);
    rd_n = 1'b1; cyc(3);
    addr = 3'd1; din = 8'h77; wr_n = 1'b0; cyc(5); wr_n = 1'b1; cyc(5);
    i_rd("R4 no-cs write dropped", 1'b0, 3'd1, 8'hA5);

    // R6: read strobe has no effect in select mode
    mode_intel = 1'b0; cyc(2);
    rd_n = 1'b0; cyc(5);
    chk("R6 rd pin ignored no drive", {7'd0, doe}, 8'd0);
    m_rd("R6 rd pin low read B0", 1'b1, 3'd0, 8'hC3);
    rd_n = 1'b1; cyc(2);
    m_rd("R6 data at cs rise", 1'b0, 3'd2, 8'h11);

    // R7: strobe-mode interrupts
    mode_intel = 1'b1; cyc(2);
    i_wr(1'b0, 3'd4, 8'h08);
    ch_irq = 2'b01; #1;
    chk("R7 a enabled", {7'd0, iaoe}, 8'd1);
    chk("R7 a level high", {7'd0, ia}, 8'd1);
    chk("R7 b disabled", {7'd0, iboe}, 8'd0);
    ch_irq = 2'b00; #1;
    chk("R7 a level low", {7'd0, ia}, 8'd0);
    i_wr(1'b1, 3'd4, 8'h08);
    ch_irq = 2'b10; #1;
    chk("R7 b enabled", {7'd0, iboe}, 8'd1);
    chk("R7 b level high", {7'd0, ib}, 8'd1);

    // R8/R9: shared open-drain line
    mode_intel = 1'b0; cyc(2);
    ch_irq = 2'b11; #1;
    chk("R8 both masked", {7'd0, iaoe}, 8'd0);
    chk("R9 b idle", {7'd0, iboe}, 8'd0);
    m_wr(1'b0, 3'd4, 8'h00);
    ch_irq = 2'b01; #1;
    chk("R8 A pulls", {7'd0, iaoe}, 8'd1);
    chk("R8 A level low", {7'd0, ia}, 8'd0);
    chk("R9 b idle A irq", {7'd0, iboe}, 8'd0);
    ch_irq = 2'b10; #1;
    chk("R8 B masked", {7'd0, iaoe}, 8'd0);
    m_wr(1'b1, 3'd4, 8'h00);
    #1;
    chk("R8 B pulls", {7'd0, iaoe}, 8'd1);
    ch_irq = 2'b00; #1;
    chk("R8 released", {7'd0, iaoe}, 8'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 8'd0, 8'd1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule